// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the internal address for a synchronous SRAM during four-beat bursts. When a new external address is loaded, the whole address is captured, and its two lowest bits become the starting offset of the burst. Each later advance request moves the low bits to the next beat's offset. The upper address bits stay as they were loaded until the next load.

A static order input selects one of two beat sequences. The first is a wrapping increment of the offset. The second XORs the starting offset with a beat count. The block also reports which beat of the burst is current. A clock-enable input freezes the whole block. The address output is registered, so the value captured at a clock edge appears on the outputs right after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `addr_out` and `beat` to zero after that edge.
- R2: With `clk_en` high and `load` high, the edge copies `addr_in` into `addr_out` and sets `beat` to 0. This happens even when `advance` is also high, because load takes priority.
- R3: With `order_ilv` low (linear order), each enabled advance without load increments `beat` by one. The offset `addr_out[1:0]` becomes (start offset + beat) mod 4, so a start of 1 gives 1,2,3,0.
- R4: With `order_ilv` high (interleaved order), each enabled advance without load increments `beat` by one. The offset `addr_out[1:0]` becomes start offset XOR beat, so a start of 1 gives 1,0,3,2.
- R5: An advance taken on the fourth beat (`beat` = 3) returns `beat` to 0 and returns the offset to the start offset.
- R6: During advances, `addr_out[ADDR_W-1:2]` keeps the value captured at the last load, whatever is on `addr_in`.
- R7: While `clk_en` is low, `addr_out` and `beat` hold their values, even when `load` or `advance` is high.
- R8: An enabled cycle with neither `load` nor `advance` leaves `addr_out` and `beat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable, active high; when low, the block holds its state |
| load | input | 1 | Capture `addr_in` and start a new burst |
| advance | input | 1 | Step to the next burst beat |
| order_ilv | input | 1 | Burst order: 0 selects linear, 1 selects interleaved; held static |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Registered internal address |
| beat | output | 2 | Index of the current beat since the last load (0 to 3) |

## Verification
Each order is driven through a complete four-beat burst and then one advance past the end. A start offset of 1 separates the two orders at every beat (linear gives 1,2,3,0 and interleaved gives 1,0,3,2). A second interleaved burst starts at offset 2, which shows that the XOR uses the loaded offset rather than a fixed one. Advances are applied with a different value on `addr_in`, to show that the upper bits stay fixed. A load issued together with an advance shows which one takes priority. Cycles with clock enable low, with either request raised, separate a true hold from an idle cycle. A reset in the middle of a burst confirms that the outputs clear.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
// Holds the start offset and the beat count and exposes their next-state values.
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             load,
  input  logic             advance,
  input  logic [OFS_W-1:0] start_in,
  output logic [OFS_W-1:0] start_d,
  output logic [OFS_W-1:0] cnt_d,
  output logic [OFS_W-1:0] cnt_q
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic [OFS_W-1:0] start_q;

  always_comb begin
    start_d = start_q;
    cnt_d   = cnt_q;
    if (rst) begin
      start_d = '0;
      cnt_d   = '0;
    end else if (clk_en) begin
      if (load) begin
        start_d = start_in;
        cnt_d   = '0;
      end else if (advance) begin
        cnt_d = cnt_q + ONE;  // wraps after the last beat
      end
    end
  end

  always_ff @(posedge clk) begin
    start_q <= start_d;
    cnt_q   <= cnt_d;
  end
endmodule

// File: rtl/burst_ofs_map.sv
// Maps a start offset and a beat count to a beat offset in the selected order.
module burst_ofs_map
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  burst_order_e     order,
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] cnt,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  genvar i;
  generate
    for (i = 0; i < OFS_W; i++) begin : g_ilv
      assign ilv_ofs[i] = start[i] ^ cnt[i];
    end
  endgenerate

  assign lin_ofs = start + cnt;
  assign ofs     = (order == ORD_INTERLEAVE) ? ilv_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load,
  input  logic              advance,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [OFS_W-1:0]  beat
);
  localparam int UP_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] start_d;
  logic [OFS_W-1:0] cnt_d;
  logic [OFS_W-1:0] ofs_d;
  logic [UP_W-1:0]  upper_q;
  logic [UP_W-1:0]  upper_d;
  burst_order_e     order;

  assign order = burst_order_e'(order_ilv);

  burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .load     (load),
    .advance  (advance),
    .start_in (addr_in[OFS_W-1:0]),
    .start_d  (start_d),
    .cnt_d    (cnt_d),
    .cnt_q    (beat)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .order (order),
    .start (start_d),
    .cnt   (cnt_d),
    .ofs   (ofs_d)
  );

  always_comb begin
    upper_d = upper_q;
    if (rst)                upper_d = '0;
    else if (clk_en && load) upper_d = addr_in[ADDR_W-1:OFS_W];
  end

  always_ff @(posedge clk) begin
    upper_q  <= upper_d;
    addr_out <= {upper_d, ofs_d};
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              load,
  input logic              advance,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [OFS_W-1:0]  beat
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic step;
  assign step = clk_en && !load && advance;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && beat == '0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && load) |=> (addr_out == $past(addr_in) && beat == '0));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !order_ilv) |=>
      (addr_out[OFS_W-1:0] == $past(addr_out[OFS_W-1:0]) + ONE && beat == $past(beat) + ONE));

  assert_ilv_step_R4: assert property (@(posedge clk) disable iff (rst)
    (step && order_ilv) |=>
      ((addr_out[OFS_W-1:0] ^ $past(addr_out[OFS_W-1:0])) == (beat ^ $past(beat))
       && beat == $past(beat) + ONE));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && beat == '1) |=> (beat == '0));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    !(clk_en && load) |=> $stable(addr_out[ADDR_W-1:OFS_W]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(addr_out) && $stable(beat)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load && !advance) |=> ($stable(addr_out) && $stable(beat)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int ADDR_W = 20;
  localparam int OFS_W  = 2;
  localparam int NV     = 19;

  typedef struct packed {
    logic              ce;
    logic              ld;
    logic              adv;
    logic              ilv;
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] ea;
    logic [OFS_W-1:0]  eb;
  } vec_t;

  // ce ld adv ilv addr_in expected_addr expected_beat
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,20'h12345,20'h12345,2'd0}, // R2 load, R3
    '{1'b1,1'b0,1'b1,1'b0,20'hAAAAA,20'h12346,2'd1}, // R3 R6
    '{1'b1,1'b0,1'b1,1'b0,20'hAAAAA,20'h12347,2'd2}, // R3
    '{1'b1,1'b0,1'b1,1'b0,20'hAAAAA,20'h12344,2'd3}, // R3 wrap of offset
    '{1'b1,1'b0,1'b1,1'b0,20'hAAAAA,20'h12345,2'd0}, // R5
    '{1'b1,1'b0,1'b0,1'b0,20'hAAAAA,20'h12345,2'd0}, // R8
    '{1'b0,1'b0,1'b1,1'b0,20'hAAAAA,20'h12345,2'd0}, // R7 advance held off
    '{1'b0,1'b1,1'b0,1'b0,20'hABCDE,20'h12345,2'd0}, // R7 load held off
    '{1'b1,1'b1,1'b1,1'b0,20'h00003,20'h00003,2'd0}, // R2 priority
    '{1'b1,1'b0,1'b1,1'b0,20'h55555,20'h00000,2'd1}, // R3
    '{1'b1,1'b1,1'b0,1'b1,20'hFFFF1,20'hFFFF1,2'd0}, // R2, R4
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'hFFFF0,2'd1}, // R4 R6
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'hFFFF3,2'd2}, // R4
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'hFFFF2,2'd3}, // R4
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'hFFFF1,2'd0}, // R5
    '{1'b1,1'b1,1'b0,1'b1,20'h55556,20'h55556,2'd0}, // R2
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'h55557,2'd1}, // R4
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'h55554,2'd2}, // R4
    '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'h55555,2'd3}  // R4
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clk_en = 1'b0;
  logic              load = 1'b0;
  logic              advance = 1'b0;
  logic              order_ilv = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [OFS_W-1:0]  beat;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .load(load), .advance(advance),
    .order_ilv(order_ilv), .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] ea, input logic [OFS_W-1:0] eb);
    checks++;
    if (addr_out !== ea || beat !== eb) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", req, addr_out, beat, ea, eb);
    end
  endtask

  // drive on falling edge, let one rising edge pass, sample on the next falling edge
  task automatic step(input logic ce, input logic ld, input logic adv, input logic ilv,
                      input logic [ADDR_W-1:0] a);
    clk_en = ce; load = ld; advance = adv; order_ilv = ilv; addr_in = a;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, 1'b0, 20'hFFFFF);
    step(1'b1, 1'b1, 1'b1, 1'b0, 20'hFFFFF);
    check("R1 reset", '0, '0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ce, VEC[i].ld, VEC[i].adv, VEC[i].ilv, VEC[i].a);
      check($sformatf("vector %0d", i), VEC[i].ea, VEC[i].eb);
    end
    // R5: advance past the last interleaved beat returns to start offset 2
    step(1'b1, 1'b0, 1'b1, 1'b1, 20'h00000);
    check("R5 wrap interleaved", 20'h55556, 2'd0);
    // R7: enable low with both requests held
    step(1'b0, 1'b1, 1'b1, 1'b1, 20'h0F0F0);
    check("R7 hold both requests", 20'h55556, 2'd0);
    // R3 from reset-start offset 0 after mid-burst reset
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b0, 20'h0F0F0);
    check("R1 mid-run reset", '0, '0);
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b1, 1'b0, 20'h0F0F0);
    check("R3 advance after reset", 20'h00001, 2'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule